// File: doc/BRIEF.md
# UART Receive/Transmit Buffering and Interrupt Controller

This block sits between a serial port's shift logic and a processor bus. It holds the characters that software writes for sending and the characters the line receiver has assembled. The core side pushes received characters into a receive queue and pops outgoing characters from a transmit queue. The bus side uses single-cycle byte reads and writes to a small register window. That window holds the data port, an interrupt enable register, a write-only queue control register, an interrupt identification register and a line status register.

One interrupt output reports the highest-priority pending source as an encoded identifier. The receive source fires once the receive queue reaches a selectable fill level. The transmit source fires when the transmit queue drains. A line-error input stands in for the receiver's error detection. The queue reset bits in the control register are one-cycle strobes and are never stored.

Register window (bus_addr): 0 reads the receive queue and writes the transmit queue. 1 is interrupt enable. 2 reads interrupt identification and writes queue control. 5 is line status. 6 reads back the queue control settings.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset: interrupt enable reads 0x00, identification reads 0x01, line status reads 0x20, address 0 reads 0x00, irq is low, tx_avail is low and rx_space is high.
- R2: Bytes written to address 0 leave on tx_data/tx_pop in write order. tx_avail is high while any byte waits. Line status bit 5 is 1 only while the transmit queue is empty.
- R3: With queues enabled the transmit queue holds 16 bytes, and a write to a full transmit queue is dropped.
- R4: Control bit 0 = 0 selects character mode, where each queue holds one byte and further pushes are dropped (rx_space low when one byte is held). Any change of control bit 0 empties both queues.
- R5: Core pushes are read back at address 0 in order. Line status bit 0 is 1 while a received byte waits. A read of an empty receive queue returns the last byte read (0x00 after reset).
- R6: Control bits 7:6 pick the receive level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. In character mode the level is 1. With enable bit 0 set, the receive source is active while the receive count is at or above the level.
- R7: Identification reads {2{enable}}, 2'b00, ID[2:0], nopend. nopend is 0 when a source is pending. The IDs are 3 for line error, 2 for receive and 1 for transmit empty, with priority in that order.
- R8: The transmit-empty source (enable bit 1) is armed when the transmit queue goes from non-empty to empty, or when enable bit 1 is written 0→1 while the queue is empty. It is active only while the queue is empty, and a read of identification that shows ID 1 disarms it.
- R9: Control bit 1 empties the receive queue and bit 2 empties the transmit queue, each in one cycle and without touching the other queue. Address 6 reads {bits 7:6, 5'b0, bit 0}, so both reset bits always read 0.
- R10: With enable bit 2 set, line_err_in high raises ID 3.
- R11: irq is high exactly when some enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects at the clock edge) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| rx_push | input | 1 | Core pushes a received byte |
| rx_push_data | input | DATA_W | Received byte |
| rx_space | output | 1 | Receive queue can accept a byte |
| tx_pop | input | 1 | Core takes the head transmit byte |
| tx_data | output | DATA_W | Head of the transmit queue |
| tx_avail | output | 1 | Transmit queue not empty |
| line_err_in | input | 1 | Line error indication (placeholder source) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong queue count or pointer shows at tx_data, tx_avail or rx_space in the very next cycle, and at the receive trigger on irq as soon as the level is crossed. A transmit-empty flag that is stuck or cleared by mistake shows on irq right after the queue drains, or right after the identification read that should have disarmed it. A wrong control register setting shows the next time the receive level is reached. Because the bench model is compared on every clock, each of these faults is caught within one or two cycles of the stimulus that exposes it.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    // register window
    localparam logic [2:0] ADR_DATA = 3'd0;
    localparam logic [2:0] ADR_IEN  = 3'd1;
    localparam logic [2:0] ADR_IDF  = 3'd2;   // read: identification, write: queue control
    localparam logic [2:0] ADR_LST  = 3'd5;
    localparam logic [2:0] ADR_QCTL = 3'd6;   // queue control readback

    typedef enum logic [2:0] {
        IRQ_NONE = 3'd0,
        IRQ_THRE = 3'd1,
        IRQ_RXDA = 3'd2,
        IRQ_LINE = 3'd3
    } irq_id_e;

    // packed: line is bit 2, thre bit 1, rxda bit 0
    typedef struct packed {
        logic line;
        logic thre;
        logic rxda;
    } ien_t;

    function automatic logic [4:0] trig_chars(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/uf_byte_fifo.sv
module uf_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          push,
    input  logic [WIDTH-1:0]              wdata,
    input  logic                          pop,
    input  logic [$clog2(DEPTH+1)-1:0]    limit,
    output logic [WIDTH-1:0]              rdata,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full,
    output logic                          empty
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0] rd_inc, wr_inc;
    logic push_ok, pop_ok;

    generate
        if (POW2) begin : g_wrap_nat
            assign rd_inc = st_q.rd + 1'b1;
            assign wr_inc = st_q.wr + 1'b1;
        end else begin : g_wrap_cmp
            assign rd_inc = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
            assign wr_inc = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
    endgenerate

    assign full    = (st_q.cnt >= limit);
    assign empty   = (st_q.cnt == '0);
    assign count   = st_q.cnt;
    assign rdata   = mem_q[st_q.rd];
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr = wr_inc;
            if (pop_ok)  st_d.rd = rd_inc;
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr] <= wdata;
    end

    // R3: occupancy never exceeds the storage
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R3: a push into a full queue leaves the count unchanged
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> $stable(st_q.cnt));

    // R9: a clear strobe empties the queue in one cycle
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/uf_irq_prio.sv
module uf_irq_prio
    import uart_fifo_pkg::*;
(
    input  ien_t    ien,
    input  logic    line_err,
    input  logic    rx_hit,
    input  logic    thre_live,
    output irq_id_e id,
    output logic    pending
);
    // later assignments override earlier ones: line > rx > tx
    always_comb begin
        id = IRQ_NONE;
        if (ien.thre && thre_live) id = IRQ_THRE;
        if (ien.rxda && rx_hit)    id = IRQ_RXDA;
        if (ien.line && line_err)  id = IRQ_LINE;
    end

    assign pending = (id != IRQ_NONE);

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
    import uart_fifo_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    output logic              rx_space,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_avail,
    input  logic              line_err_in,
    output logic              irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        ien_t              ien;
        logic              fifo_en;
        logic [1:0]        trig;
        logic              thre_pend;
        logic [DATA_W-1:0] rx_last;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic wr_data, wr_ien, wr_qctl, rd_data, rd_idf;
    logic en_change, rx_clr, tx_clr;
    logic [CW-1:0] q_limit, rx_level;
    logic [CW-1:0] rx_cnt, tx_cnt;
    logic rx_full, rx_empty, tx_full, tx_empty;
    logic [DATA_W-1:0] rx_head;
    logic rx_hit, thre_live, thre_arm, tx_going_empty;
    logic tx_push_ok, tx_pop_ok;
    irq_id_e irq_id;
    logic irq_pend;

    // ---------------- bus decode ----------------
    assign wr_data   = bus_wr && (bus_addr == ADR_DATA);
    assign wr_ien    = bus_wr && (bus_addr == ADR_IEN);
    assign wr_qctl   = bus_wr && (bus_addr == ADR_IDF);
    assign rd_data   = bus_rd && (bus_addr == ADR_DATA);
    assign rd_idf    = bus_rd && (bus_addr == ADR_IDF);

    assign en_change = wr_qctl && (bus_wdata[0] != ctl_q.fifo_en);
    assign rx_clr    = wr_qctl && (bus_wdata[1] || en_change);
    assign tx_clr    = wr_qctl && (bus_wdata[2] || en_change);

    assign q_limit   = ctl_q.fifo_en ? CW'(FIFO_DEPTH) : CW'(1);
    assign rx_level  = ctl_q.fifo_en ? CW'(trig_chars(ctl_q.trig)) : CW'(1);

    // ---------------- queues ----------------
    uf_byte_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (wr_data),
        .wdata (bus_wdata),
        .pop   (tx_pop),
        .limit (q_limit),
        .rdata (tx_data),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    uf_byte_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push),
        .wdata (rx_push_data),
        .pop   (rd_data),
        .limit (q_limit),
        .rdata (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign rx_space  = !rx_full;
    assign tx_avail  = !tx_empty;

    // ---------------- interrupt sources ----------------
    assign rx_hit         = (rx_cnt >= rx_level);
    assign thre_live      = ctl_q.thre_pend && tx_empty;
    assign tx_push_ok     = wr_data && !tx_full;
    assign tx_pop_ok      = tx_pop && !tx_empty;
    assign tx_going_empty = (tx_clr && !tx_empty)
                         || (tx_pop_ok && (tx_cnt == CW'(1)) && !tx_push_ok);
    assign thre_arm       = wr_ien && bus_wdata[1] && !ctl_q.ien.thre && tx_empty;

    uf_irq_prio u_prio (
        .ien       (ctl_q.ien),
        .line_err  (line_err_in),
        .rx_hit    (rx_hit),
        .thre_live (thre_live),
        .id        (irq_id),
        .pending   (irq_pend)
    );

    assign irq = irq_pend;

    // ---------------- next state ----------------
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ien) ctl_d.ien = ien_t'(bus_wdata[2:0]);
        if (rd_idf && (irq_id == IRQ_THRE)) ctl_d.thre_pend = 1'b0;
        if (thre_arm || tx_going_empty)     ctl_d.thre_pend = 1'b1;
        if (wr_qctl) begin
            ctl_d.fifo_en = bus_wdata[0];
            ctl_d.trig    = bus_wdata[7:6];
        end
        if (rd_data && !rx_empty) ctl_d.rx_last = rx_head;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_DATA: bus_rdata = rx_empty ? ctl_q.rx_last : rx_head;
            ADR_IEN:  bus_rdata = DATA_W'({5'b0, ctl_q.ien});
            ADR_IDF:  bus_rdata = DATA_W'({{2{ctl_q.fifo_en}}, 2'b00, irq_id, !irq_pend});
            ADR_LST:  bus_rdata = DATA_W'({2'b00, tx_empty, 4'b0000, !rx_empty});
            ADR_QCTL: bus_rdata = DATA_W'({ctl_q.trig, 5'b00000, ctl_q.fifo_en});
            default:  bus_rdata = '0;
        endcase
    end

    // ---------------- assertions ----------------
    // R6: receive level reached with the source enabled shows ID 2 unless line error outranks it
    assert_rx_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ien.rxda && rx_hit && !(ctl_q.ien.line && line_err_in)) |-> (irq_id == IRQ_RXDA));

    // R8: reading identification while it shows ID 1 disarms the transmit source
    assert_thre_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idf && (irq_id == IRQ_THRE) && !tx_going_empty) |=> (irq_id != IRQ_THRE));

    // R7: the no-pending bit of identification is the inverse of the interrupt pin
    assert_nopend_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idf |-> (bus_rdata[0] == !irq));

    // R5: reading an empty receive queue keeps the last byte read
    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rx_empty) |=> $stable(ctl_q.rx_last));

    // R4: character mode never holds more than one byte per queue
    assert_char_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.fifo_en |-> ((rx_cnt <= CW'(1)) && (tx_cnt <= CW'(1))));

endmodule

// File: tb/tb_uart_fifo_irq.sv
module tb_uart_fifo_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_push = 1'b0;
    logic [7:0] rx_push_data = '0;
    logic       rx_space;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_data;
    logic       tx_avail;
    logic       line_err_in = 1'b0;
    logic       irq;

    always #10 clk = ~clk;   // 50 MHz

    uart_fifo_irq dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_push(rx_push),
        .rx_push_data(rx_push_data), .rx_space(rx_space), .tx_pop(tx_pop),
        .tx_data(tx_data), .tx_avail(tx_avail), .line_err_in(line_err_in), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // ---------------- behavioural reference model ----------------
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [2:0] m_ier;
    bit         m_en, m_thre;
    logic [1:0] m_trig;
    logic [7:0] m_last;
    int  tsz, rsz, ql;
    bit  tpush, tpop, rpush, rpop, wrf, wri, enchg, tclr, rclr, gone;
    logic [2:0] id0;

    function automatic int qlim();
        return m_en ? 16 : 1;
    endfunction

    function automatic int rlevel();
        if (!m_en) return 1;
        case (m_trig)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [2:0] mid();
        if (m_ier[2] && line_err_in) return 3'd3;
        if (m_ier[0] && rxq.size() >= rlevel()) return 3'd2;
        if (m_ier[1] && m_thre && txq.size() == 0) return 3'd1;
        return 3'd0;
    endfunction

    function automatic logic [7:0] mread(input logic [2:0] a);
        case (a)
            3'd0: return (rxq.size() != 0) ? rxq[0] : m_last;
            3'd1: return {5'b0, m_ier};
            3'd2: return {m_en, m_en, 2'b00, mid(), mid() == 3'd0};
            3'd5: return {2'b00, txq.size() == 0, 4'b0000, rxq.size() != 0};
            3'd6: return {m_trig, 5'b00000, m_en};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_ier = '0; m_en = 1'b0; m_thre = 1'b0; m_trig = '0; m_last = '0;
        end else begin
            id0   = mid();
            tsz   = txq.size();
            rsz   = rxq.size();
            ql    = qlim();
            tpush = bus_wr && bus_addr == 3'd0 && tsz < ql;
            tpop  = tx_pop && tsz > 0;
            rpush = rx_push && rsz < ql;
            rpop  = bus_rd && bus_addr == 3'd0 && rsz > 0;
            wri   = bus_wr && bus_addr == 3'd1;
            wrf   = bus_wr && bus_addr == 3'd2;
            enchg = wrf && (bus_wdata[0] != m_en);
            tclr  = wrf && (bus_wdata[2] || enchg);
            rclr  = wrf && (bus_wdata[1] || enchg);
            gone  = (tclr && tsz != 0) || (tpop && tsz == 1 && !tpush);
            if (tpop)  void'(txq.pop_front());
            if (tpush) txq.push_back(bus_wdata);
            if (rpop)  m_last = rxq.pop_front();
            if (rpush) rxq.push_back(rx_push_data);
            if (bus_rd && bus_addr == 3'd2 && id0 == 3'd1) m_thre = 1'b0;
            if (wri && bus_wdata[1] && !m_ier[1] && tsz == 0) m_thre = 1'b1;
            if (gone) m_thre = 1'b1;
            if (wri) m_ier = bus_wdata[2:0];
            if (wrf) begin m_en = bus_wdata[0]; m_trig = bus_wdata[7:6]; end
            if (tclr) txq.delete();
            if (rclr) rxq.delete();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, 2 ns before the rising edge
    always begin
        @(negedge clk);
        #8;
        if (rst_n && !done) begin
            chk(irq == (mid() != 3'd0), "R11", "irq pin", int'(irq), int'(mid() != 3'd0));
            chk(tx_avail == (txq.size() != 0), "R2", "tx_avail", int'(tx_avail), int'(txq.size() != 0));
            if (txq.size() != 0)
                chk(tx_data == txq[0], "R2", "tx_data", int'(tx_data), int'(txq[0]));
            chk(rx_space == (rxq.size() < qlim()), "R4", "rx_space", int'(rx_space), int'(rxq.size() < qlim()));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #8;
        chk(bus_rdata == exp, tag, "register read", int'(bus_rdata), int'(exp));
        chk(bus_rdata == mread(a), tag, "model read", int'(bus_rdata), int'(mread(a)));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_push_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop(input logic [7:0] exp, input string tag);
        @(negedge clk);
        chk(tx_avail && tx_data == exp, tag, "tx head", int'(tx_data), int'(exp));
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic pin(input bit act, input bit exp, input string tag, input string what);
        #1;
        chk(act == exp, tag, what, int'(act), int'(exp));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        pin(irq, 1'b0, "R1", "irq after reset");
        pin(rx_space, 1'b1, "R1", "rx_space after reset");
        rd(3'd1, 8'h00, "R1");
        rd(3'd2, 8'h01, "R1");
        rd(3'd5, 8'h20, "R1");
        rd(3'd0, 8'h00, "R1");

        // R2 transmit order
        wr(3'd2, 8'h01);
        rd(3'd6, 8'h01, "R9");
        rd(3'd2, 8'hC1, "R7");
        wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
        rd(3'd5, 8'h00, "R2");
        pop(8'h11, "R2"); pop(8'h22, "R2"); pop(8'h33, "R2");
        rd(3'd5, 8'h20, "R2");

        // R3 sixteen-deep transmit queue, 17th write dropped
        for (int i = 0; i < 17; i++) wr(3'd0, 8'(8'h40 + i));
        for (int i = 0; i < 16; i++) pop(8'(8'h40 + i), "R3");
        pin(tx_avail, 1'b0, "R3", "tx empty after 16 pops");

        // R8 transmit-empty source
        wr(3'd1, 8'h02);
        pin(irq, 1'b1, "R8", "armed on enable");
        rd(3'd2, 8'hC2, "R8");
        rd(3'd2, 8'hC1, "R8");
        wr(3'd0, 8'h5A);
        pin(irq, 1'b0, "R8", "no irq while queue holds data");
        pop(8'h5A, "R8");
        pin(irq, 1'b1, "R8", "armed on drain");
        rd(3'd2, 8'hC2, "R8");
        rd(3'd2, 8'hC1, "R8");
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h02);
        rd(3'd2, 8'hC2, "R8");
        wr(3'd1, 8'h00);

        // R5 receive path
        push(8'hA1); push(8'hA2); push(8'hA3);
        rd(3'd5, 8'h21, "R5");
        rd(3'd0, 8'hA1, "R5"); rd(3'd0, 8'hA2, "R5"); rd(3'd0, 8'hA3, "R5");
        rd(3'd5, 8'h20, "R5");
        rd(3'd0, 8'hA3, "R5");

        // R6 receive levels
        wr(3'd1, 8'h01);
        for (int t = 0; t < 4; t++) begin
            int lv;
            lv = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
            wr(3'd2, 8'((t << 6) | 3));
            for (int k = 1; k <= lv; k++) begin
                push(8'(k));
                pin(irq, k >= lv, "R6", "receive level");
            end
        end
        rd(3'd2, 8'hC4, "R6");

        // R9 reset strobes
        wr(3'd2, 8'hC7);
        rd(3'd6, 8'hC1, "R9");
        rd(3'd5, 8'h20, "R9");
        pin(irq, 1'b0, "R9", "rx cleared");
        push(8'h77);
        wr(3'd0, 8'h01); wr(3'd0, 8'h02);
        wr(3'd2, 8'hC5);
        pin(tx_avail, 1'b0, "R9", "tx cleared");
        rd(3'd5, 8'h21, "R9");
        rd(3'd0, 8'h77, "R9");

        // R7 / R10 priority
        wr(3'd2, 8'h01);
        wr(3'd1, 8'h07);
        push(8'h88);
        rd(3'd2, 8'hC4, "R7");
        @(negedge clk); line_err_in = 1'b1;
        rd(3'd2, 8'hC6, "R10");
        @(negedge clk); line_err_in = 1'b0;
        rd(3'd2, 8'hC4, "R7");
        rd(3'd0, 8'h88, "R7");
        rd(3'd2, 8'hC2, "R7");
        rd(3'd2, 8'hC1, "R8");

        // R4 character mode
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        rd(3'd2, 8'h01, "R4");
        push(8'hB1);
        pin(rx_space, 1'b0, "R4", "one byte fills rx");
        push(8'hB2);
        rd(3'd0, 8'hB1, "R4");
        rd(3'd0, 8'hB1, "R5");
        wr(3'd0, 8'hD1); wr(3'd0, 8'hD2);
        pop(8'hD1, "R4");
        pin(tx_avail, 1'b0, "R4", "second tx byte dropped");
        wr(3'd1, 8'h01);
        wr(3'd2, 8'hC0);
        push(8'hB3);
        pin(irq, 1'b1, "R6", "level 1 in character mode");
        wr(3'd2, 8'h01);
        pin(irq, 1'b0, "R4", "mode change empties rx");
        rd(3'd5, 8'h20, "R4");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule